// File: doc/BRIEF.md
# Serial Port Register Interface

This block is the software-facing front end of a byte-oriented serial port. A simple 32-bit bus slave exposes two word registers. The control/status word at byte offset 0x00 holds the line configuration, the interrupt enables and live FIFO status. The data word at byte offset 0x04 is the window into the two byte FIFOs. Writing the data word queues a byte for transmission. Reading the data word takes the oldest received byte.

Toward the serial engine, the block offers a transmit byte stream and accepts a receive byte stream, both valid/ready. The transmit stream presents the head of the TX FIFO while the port is enabled. A byte leaves only in a cycle where valid and ready are both high. While valid is high and ready is low, the byte on the stream does not change. The one exception is a TX flush or a disable, which withdraws valid. The receive stream is ready whenever the port is enabled. A byte offered while the RX FIFO is full is accepted and discarded, and it raises the overrun flag, so the engine is never stalled. The engine reports a busy flag, which is folded into the status word. Two interrupt lines, one for receive and one for transmit, are formed from the status flags and their enables.

Bus reads are registered: the read data appears in the cycle after the read strobe. A data-word read pops the RX FIFO in that same edge.

Top module: `uart_regif`

## Requirements
- R1: After reset, the control word reads 0x00180000 (only TX-empty at bit 19 and TX-not-half at bit 20 set). Both interrupt lines are low, `tx_out_valid` is low and `rx_in_ready` is low.
- R2: A write to offset 0x00 stores bit 0 enable, bit 1 simulation mode, bit 2 flow control, bits 5:3 prescaler and bits 15:6 divisor on the configuration outputs and in the readback. It also stores the interrupt enables in bits 26:22.
- R3: A write to offset 0x04 queues bits 7:0 into the TX FIFO. While the FIFO is full, the write is dropped. Queued bytes leave on the transmit stream in write order.
- R4: `tx_out_valid` is high only when the port is enabled and the TX FIFO holds a byte. While it is stalled by a low `tx_out_ready`, `tx_out_data` holds its value.
- R5: A read of offset 0x04 returns the oldest RX byte in bits 7:0, log2 of the RX depth in bits 11:8 and log2 of the TX depth in bits 15:12, and pops that byte. On an empty FIFO, bits 7:0 read 0.
- R6: `rx_in_ready` equals the enable bit. An accepted byte is stored when the RX FIFO is not full.
- R7: Bit 30 (RX overrun) sets when a byte is accepted while the RX FIFO is full. The byte is lost. The flag clears on an RX flush or on a control write with bit 0 low.
- R8: The status bits read live: bit 16 RX not empty, bit 17 RX at least half full, bit 18 RX full, bit 19 TX empty, bit 20 TX below half, bit 21 TX full. Bit 31 is set when the engine is busy or the TX FIFO is not empty.
- R9: Writing 1 to control bit 28 empties the RX FIFO, and writing 1 to bit 29 empties the TX FIFO. Both bits always read back as 0.
- R10: `irq_rx` is high when enabled and any of these holds: bit 22 and RX not empty, bit 23 and RX half, or bit 24 and RX full.
- R11: `irq_tx` is high when enabled and either of these holds: bit 25 and TX empty, or bit 26 and TX below half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| tx_out_valid | output | 1 | Transmit byte available |
| tx_out_ready | input | 1 | Engine takes the transmit byte |
| tx_out_data | output | 8 | Transmit byte |
| rx_in_valid | input | 1 | Engine offers a received byte |
| rx_in_ready | output | 1 | Port accepts received bytes |
| rx_in_data | input | 8 | Received byte |
| eng_busy | input | 1 | Engine is shifting a frame |
| cfg_enable | output | 1 | Port enable |
| cfg_sim | output | 1 | Simulation mode select |
| cfg_flow | output | 1 | Hardware flow-control enable |
| cfg_prescale | output | 3 | Clock prescaler select |
| cfg_divisor | output | 10 | Baud divisor |
| irq_rx | output | 1 | Receive interrupt |
| irq_tx | output | 1 | Transmit interrupt |

## Verification
The assertions watch stream and register behaviour on every cycle:
- transmit valid is gated by enable;
- a stalled transmit byte holds its value;
- a flush empties the TX FIFO and clears overrun by the next cycle;
- an empty data read returns 0;
- a disabled port raises no interrupt and accepts nothing.

Byte ordering, the drop of a write to a full FIFO, the exact fill levels at which the half and full flags and the interrupts change, and overrun recovery by a disable all need the bench's scenarios. The bench's scoreboard compares every transmitted and every read byte against its expected queue.

// File: rtl/uart_regif_pkg.sv
package uart_regif_pkg;

  // Control word bit positions that software decodes
  localparam int unsigned BIT_RX_NE    = 16;
  localparam int unsigned BIT_RX_HALF  = 17;
  localparam int unsigned BIT_RX_FULL  = 18;
  localparam int unsigned BIT_TX_EMPTY = 19;
  localparam int unsigned BIT_TX_NHALF = 20;
  localparam int unsigned BIT_TX_FULL  = 21;
  localparam int unsigned BIT_IE_LO    = 22;
  localparam int unsigned BIT_IE_HI    = 26;
  localparam int unsigned BIT_RX_FLUSH = 28;
  localparam int unsigned BIT_TX_FLUSH = 29;
  localparam int unsigned BIT_RX_OVR   = 30;
  localparam int unsigned BIT_BUSY     = 31;

  // Line configuration, packed so that enable is bit 0 and divisor bits 15:6
  typedef struct packed {
    logic [9:0] divisor;
    logic [2:0] prescale;
    logic       flow;
    logic       sim;
    logic       enable;
  } line_cfg_t;

  // Interrupt enables, packed to match bits 26:22
  typedef struct packed {
    logic tx_nhalf;
    logic tx_empty;
    logic rx_full;
    logic rx_half;
    logic rx_ne;
  } irq_en_t;

endpackage

// File: rtl/regif_byte_fifo.sv
module regif_byte_fifo #(
  parameter int unsigned DEPTH_LOG2 = 4,
  parameter int unsigned WIDTH      = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  flush,
  input  logic                  push,
  input  logic [WIDTH-1:0]      push_data,
  input  logic                  pop,
  output logic [WIDTH-1:0]      head,
  output logic [DEPTH_LOG2:0]   level,
  output logic                  empty,
  output logic                  full
);
  localparam int unsigned DEPTH = 1 << DEPTH_LOG2;

  logic [WIDTH-1:0]      mem [DEPTH];
  logic [DEPTH_LOG2-1:0] wr_ptr, rd_ptr;
  logic                  do_push, do_pop;

  assign empty   = (level == '0);
  assign full    = level[DEPTH_LOG2];
  assign do_push = push && !full && !flush;
  assign do_pop  = pop && !empty && !flush;
  assign head    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/regif_irq.sv
module regif_irq
  import uart_regif_pkg::*;
(
  input  logic    enable,
  input  irq_en_t ie,
  input  logic    rx_ne,
  input  logic    rx_half,
  input  logic    rx_full,
  input  logic    tx_empty,
  input  logic    tx_nhalf,
  output logic    irq_rx,
  output logic    irq_tx
);
  logic [2:0] rx_terms;
  logic [1:0] tx_terms;

  always_comb begin
    rx_terms = {ie.rx_full & rx_full, ie.rx_half & rx_half, ie.rx_ne & rx_ne};
    tx_terms = {ie.tx_nhalf & tx_nhalf, ie.tx_empty & tx_empty};
    irq_rx   = enable & (|rx_terms);
    irq_tx   = enable & (|tx_terms);
  end
endmodule

// File: rtl/uart_regif.sv
module uart_regif
  import uart_regif_pkg::*;
#(
  parameter int unsigned ADDR_W  = 4,
  parameter int unsigned RX_LOG2 = 4,
  parameter int unsigned TX_LOG2 = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_rd,
  output logic [31:0]       bus_rdata,
  output logic              tx_out_valid,
  input  logic              tx_out_ready,
  output logic [7:0]        tx_out_data,
  input  logic              rx_in_valid,
  output logic              rx_in_ready,
  input  logic [7:0]        rx_in_data,
  input  logic              eng_busy,
  output logic              cfg_enable,
  output logic              cfg_sim,
  output logic              cfg_flow,
  output logic [2:0]        cfg_prescale,
  output logic [9:0]        cfg_divisor,
  output logic              irq_rx,
  output logic              irq_tx
);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = '0;
  localparam logic [ADDR_W-1:0] DATA_ADDR = ADDR_W'(4);
  localparam logic [RX_LOG2:0]  RX_HALF   = (RX_LOG2+1)'(1) << (RX_LOG2-1);
  localparam logic [TX_LOG2:0]  TX_HALF   = (TX_LOG2+1)'(1) << (TX_LOG2-1);
  localparam logic [3:0]        RX_LOG2_F = 4'(RX_LOG2);
  localparam logic [3:0]        TX_LOG2_F = 4'(TX_LOG2);

  line_cfg_t cfg_q;
  irq_en_t   ie_q;
  logic      ovr_q;

  logic ctrl_wr, data_wr, ctrl_rd, data_rd;
  logic rx_flush, tx_flush, rx_take;
  logic [7:0]       rx_head;
  logic [RX_LOG2:0] rx_level;
  logic [TX_LOG2:0] tx_level;
  logic rx_empty, rx_full, tx_empty, tx_full, rx_half, tx_nhalf;
  logic [31:0] ctrl_image;
  logic unused_wdata;

  assign unused_wdata = ^{bus_wdata[31:30], bus_wdata[27], bus_wdata[21:16]};

  // Address decode
  assign ctrl_wr  = bus_wr && (bus_addr == CTRL_ADDR);
  assign data_wr  = bus_wr && (bus_addr == DATA_ADDR);
  assign ctrl_rd  = bus_rd && (bus_addr == CTRL_ADDR);
  assign data_rd  = bus_rd && (bus_addr == DATA_ADDR);
  assign rx_flush = ctrl_wr && bus_wdata[BIT_RX_FLUSH];
  assign tx_flush = ctrl_wr && bus_wdata[BIT_TX_FLUSH];

  // Configuration and interrupt-enable storage
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q <= '0;
      ie_q  <= '0;
    end else if (ctrl_wr) begin
      cfg_q <= line_cfg_t'(bus_wdata[15:0]);
      ie_q  <= irq_en_t'(bus_wdata[BIT_IE_HI:BIT_IE_LO]);
    end
  end

  assign cfg_enable   = cfg_q.enable;
  assign cfg_sim      = cfg_q.sim;
  assign cfg_flow     = cfg_q.flow;
  assign cfg_prescale = cfg_q.prescale;
  assign cfg_divisor  = cfg_q.divisor;

  // Transmit path
  regif_byte_fifo #(.DEPTH_LOG2(TX_LOG2), .WIDTH(8)) u_tx_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (tx_flush),
    .push      (data_wr),
    .push_data (bus_wdata[7:0]),
    .pop       (tx_out_valid && tx_out_ready),
    .head      (tx_out_data),
    .level     (tx_level),
    .empty     (tx_empty),
    .full      (tx_full)
  );

  assign tx_out_valid = cfg_q.enable && !tx_empty;

  // Receive path
  assign rx_in_ready = cfg_q.enable;
  assign rx_take     = rx_in_valid && rx_in_ready;

  regif_byte_fifo #(.DEPTH_LOG2(RX_LOG2), .WIDTH(8)) u_rx_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (rx_flush),
    .push      (rx_take),
    .push_data (rx_in_data),
    .pop       (data_rd),
    .head      (rx_head),
    .level     (rx_level),
    .empty     (rx_empty),
    .full      (rx_full)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovr_q <= 1'b0;
    end else if (rx_flush || (ctrl_wr && !bus_wdata[0])) begin
      ovr_q <= 1'b0;
    end else if (rx_take && rx_full) begin
      ovr_q <= 1'b1;
    end
  end

  assign rx_half  = (rx_level >= RX_HALF);
  assign tx_nhalf = (tx_level <  TX_HALF);

  // Status image
  always_comb begin
    ctrl_image                          = '0;
    ctrl_image[15:0]                    = cfg_q;
    ctrl_image[BIT_RX_NE]               = !rx_empty;
    ctrl_image[BIT_RX_HALF]             = rx_half;
    ctrl_image[BIT_RX_FULL]             = rx_full;
    ctrl_image[BIT_TX_EMPTY]            = tx_empty;
    ctrl_image[BIT_TX_NHALF]            = tx_nhalf;
    ctrl_image[BIT_TX_FULL]             = tx_full;
    ctrl_image[BIT_IE_HI:BIT_IE_LO]     = ie_q;
    ctrl_image[BIT_RX_OVR]              = ovr_q;
    ctrl_image[BIT_BUSY]                = eng_busy || !tx_empty;
  end

  // Registered read port
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata <= '0;
    end else if (ctrl_rd) begin
      bus_rdata <= ctrl_image;
    end else if (data_rd) begin
      bus_rdata <= {16'h0, TX_LOG2_F, RX_LOG2_F, rx_empty ? 8'h00 : rx_head};
    end else if (bus_rd) begin
      bus_rdata <= '0;
    end
  end

  regif_irq u_irq (
    .enable   (cfg_q.enable),
    .ie       (ie_q),
    .rx_ne    (!rx_empty),
    .rx_half  (rx_half),
    .rx_full  (rx_full),
    .tx_empty (tx_empty),
    .tx_nhalf (tx_nhalf),
    .irq_rx   (irq_rx),
    .irq_tx   (irq_tx)
  );
endmodule

// File: rtl/uart_regif_chk.sv
module uart_regif_chk #(
  parameter int unsigned ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [31:0]       bus_wdata,
  input logic              bus_rd,
  input logic [31:0]       bus_rdata,
  input logic              tx_out_valid,
  input logic              tx_out_ready,
  input logic [7:0]        tx_out_data,
  input logic              rx_in_ready,
  input logic              cfg_enable,
  input logic              irq_rx,
  input logic              irq_tx,
  input logic              rx_empty,
  input logic              ovr_q
);
  logic unused_chk;
  assign unused_chk = ^{bus_wdata[31:30], bus_wdata[27:1], bus_rdata[31:8]};

  assert_tx_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_out_valid |-> cfg_enable);

  assert_tx_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_out_valid && !tx_out_ready) |=> (!tx_out_valid || $stable(tx_out_data)));

  assert_tx_flush_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(0) && bus_wdata[29]) |=> !tx_out_valid);

  assert_ovr_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(0) && bus_wdata[28]) |=> !ovr_q);

  assert_empty_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == ADDR_W'(4) && rx_empty) |=> (bus_rdata[7:0] == 8'h00));

  assert_rx_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_enable |-> !rx_in_ready);

  assert_irq_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_enable |-> (!irq_rx && !irq_tx));

  assert_cfg_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(0)) |=> (cfg_enable == $past(bus_wdata[0])));
endmodule

bind uart_regif uart_regif_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_addr     (bus_addr),
  .bus_wr       (bus_wr),
  .bus_wdata    (bus_wdata),
  .bus_rd       (bus_rd),
  .bus_rdata    (bus_rdata),
  .tx_out_valid (tx_out_valid),
  .tx_out_ready (tx_out_ready),
  .tx_out_data  (tx_out_data),
  .rx_in_ready  (rx_in_ready),
  .cfg_enable   (cfg_enable),
  .irq_rx       (irq_rx),
  .irq_tx       (irq_tx),
  .rx_empty     (rx_empty),
  .ovr_q        (ovr_q)
);

// File: tb/test_uart_regif.sv
`timescale 1ns/1ps
module test_uart_regif;
  localparam int unsigned ADDR_W = 4;
  localparam logic [31:0] CFG = 32'h0000AAEF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic tx_out_valid, tx_out_ready = 1'b0;
  logic [7:0] tx_out_data;
  logic rx_in_valid = 1'b0, rx_in_ready;
  logic [7:0] rx_in_data = '0;
  logic eng_busy = 1'b0;
  logic cfg_enable, cfg_sim, cfg_flow;
  logic [2:0] cfg_prescale;
  logic [9:0] cfg_divisor;
  logic irq_rx, irq_tx;

  int n_tests = 0, n_fail = 0;
  logic [7:0] txq[$];
  logic [7:0] rxq[$];
  bit tx_stall = 1'b1;
  int unsigned cyc = 0;
  logic [31:0] rd;

  always #2.5 clk = ~clk;

  uart_regif #(.ADDR_W(ADDR_W)) i_uart_regif (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .tx_out_valid(tx_out_valid), .tx_out_ready(tx_out_ready), .tx_out_data(tx_out_data),
    .rx_in_valid(rx_in_valid), .rx_in_ready(rx_in_ready), .rx_in_data(rx_in_data),
    .eng_busy(eng_busy), .cfg_enable(cfg_enable), .cfg_sim(cfg_sim), .cfg_flow(cfg_flow),
    .cfg_prescale(cfg_prescale), .cfg_divisor(cfg_divisor), .irq_rx(irq_rx), .irq_tx(irq_tx)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(logic [ADDR_W-1:0] a, logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic bus_read(logic [ADDR_W-1:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  // Driver: queue the byte if it is expected on the transmit stream
  task automatic send_byte(logic [7:0] b, bit expect_out);
    if (expect_out) txq.push_back(b);
    bus_write(ADDR_W'(4), {24'h0, b});
  endtask

  task automatic rx_send(logic [7:0] b, bit expect_kept);
    if (expect_kept) rxq.push_back(b);
    @(negedge clk); rx_in_valid = 1'b1; rx_in_data = b;
    @(negedge clk); rx_in_valid = 1'b0;
  endtask

  task automatic rx_pop_check(string req);
    logic [7:0] e;
    bus_read(ADDR_W'(4), rd);
    e = (rxq.size() > 0) ? rxq.pop_front() : 8'h00;
    check(req, {16'h0, rd[15:0]}, {16'h0, 8'h44, e});
  endtask

  task automatic drain_tx();
    tx_stall = 1'b0;
    for (int i = 0; i < 400 && txq.size() > 0; i++) @(negedge clk);
    check("R3 drained", txq.size(), 0);
  endtask

  // Monitor: drives ready and scores every handshake
  always @(negedge clk) begin
    cyc++;
    tx_out_ready = !tx_stall && (cyc[1:0] != 2'b11);
    if (tx_out_valid && tx_out_ready) begin
      if (txq.size() == 0) begin
        n_tests++; n_fail++;
        $display("FAIL R3 actual=%h expected=none", tx_out_data);
      end else begin
        check("R3 tx order", {24'h0, tx_out_data}, {24'h0, txq.pop_front()});
      end
    end
  end

  initial begin
    #(200000 * 5);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 irq", {30'h0, irq_rx, irq_tx}, 0);
    check("R1 tx_valid", {31'h0, tx_out_valid}, 0);
    check("R1 rx_ready", {31'h0, rx_in_ready}, 0);
    bus_read(ADDR_W'(0), rd);
    check("R1 ctrl", rd, 32'h00180000);

    // R2 configuration fields
    bus_write(ADDR_W'(0), CFG);
    check("R2 cfg", {cfg_divisor, cfg_prescale, cfg_flow, cfg_sim, cfg_enable},
          {10'h2AB, 3'd5, 1'b1, 1'b1, 1'b1});
    bus_read(ADDR_W'(0), rd);
    check("R2 readback", rd, 32'h0018AAEF);

    // R3/R4/R8 fill TX while stalled, extra write dropped
    tx_stall = 1'b1;
    for (int i = 0; i < 16; i++) send_byte(8'(8'h30 + i), 1'b1);
    send_byte(8'hFF, 1'b0);
    check("R4 valid", {31'h0, tx_out_valid}, 1);
    bus_read(ADDR_W'(0), rd);
    check("R8 tx full flags", {29'h0, rd[21:19]}, 3'b100);
    check("R8 busy", {31'h0, rd[31]}, 1);
    drain_tx();
    bus_read(ADDR_W'(0), rd);
    check("R8 tx empty", {29'h0, rd[21:19]}, 3'b011);

    // R9 TX flush
    tx_stall = 1'b1;
    for (int i = 0; i < 3; i++) send_byte(8'(i), 1'b0);
    bus_write(ADDR_W'(0), CFG | 32'h20000000);
    check("R9 tx flushed", {31'h0, tx_out_valid}, 0);
    bus_read(ADDR_W'(0), rd);
    check("R9 readback", {29'h0, rd[29], rd[28], rd[19]}, 3'b001);
    tx_stall = 1'b0;

    // R5/R6 receive and read
    check("R6 ready", {31'h0, rx_in_ready}, 1);
    rx_send(8'hA1, 1'b1); rx_send(8'hB2, 1'b1); rx_send(8'hC3, 1'b1);
    for (int i = 0; i < 3; i++) rx_pop_check("R5 rx byte");
    rx_pop_check("R5 empty read");

    // R7/R8 fill RX, overrun, flush
    for (int i = 0; i < 16; i++) rx_send(8'(i), 1'b1);
    bus_read(ADDR_W'(0), rd);
    check("R8 rx flags", {29'h0, rd[18:16]}, 3'b111);
    rx_send(8'hEE, 1'b0);
    bus_read(ADDR_W'(0), rd);
    check("R7 overrun set", {31'h0, rd[30]}, 1);
    rx_pop_check("R7 first kept");
    bus_read(ADDR_W'(0), rd);
    check("R8 rx 15", {29'h0, rd[18:16]}, 3'b011);
    bus_write(ADDR_W'(0), CFG | 32'h10000000);
    rxq.delete();
    bus_read(ADDR_W'(0), rd);
    check("R9 rx flush", {29'h0, rd[30], rd[28], rd[16]}, 3'b000);

    // R7 disable clears overrun
    for (int i = 0; i < 17; i++) rx_send(8'(i), 1'b0);
    bus_write(ADDR_W'(0), 32'h0);
    bus_read(ADDR_W'(0), rd);
    check("R7 disable clears", {30'h0, rd[30], rd[16]}, 2'b01);
    bus_write(ADDR_W'(0), CFG | 32'h10000000);

    // R10 receive interrupt
    bus_write(ADDR_W'(0), CFG | 32'h00400000);
    check("R10 idle", {31'h0, irq_rx}, 0);
    rx_send(8'h5A, 1'b1);
    check("R10 ne", {31'h0, irq_rx}, 1);
    rx_pop_check("R10 pop");
    check("R10 cleared", {31'h0, irq_rx}, 0);
    bus_write(ADDR_W'(0), CFG | 32'h00800000);
    for (int i = 0; i < 7; i++) rx_send(8'(i), 1'b0);
    check("R10 below half", {31'h0, irq_rx}, 0);
    rx_send(8'h07, 1'b0);
    check("R10 half", {31'h0, irq_rx}, 1);
    bus_write(ADDR_W'(0), CFG | 32'h11000000);
    for (int i = 0; i < 15; i++) rx_send(8'(i), 1'b0);
    check("R10 not full", {31'h0, irq_rx}, 0);
    rx_send(8'h0F, 1'b0);
    check("R10 full", {31'h0, irq_rx}, 1);
    bus_write(ADDR_W'(0), (CFG & ~32'h1) | 32'h12000000);
    check("R11 disabled", {30'h0, irq_rx, irq_tx}, 0);

    // R11 transmit interrupt
    bus_write(ADDR_W'(0), CFG | 32'h02000000);
    check("R11 empty", {31'h0, irq_tx}, 1);
    tx_stall = 1'b1;
    send_byte(8'h55, 1'b1);
    check("R11 not empty", {31'h0, irq_tx}, 0);
    bus_write(ADDR_W'(0), CFG | 32'h04000000);
    check("R11 below half", {31'h0, irq_tx}, 1);
    for (int i = 0; i < 7; i++) send_byte(8'(8'h60 + i), 1'b1);
    check("R11 at half", {31'h0, irq_tx}, 0);
    drain_tx();

    // R8 engine busy
    eng_busy = 1'b1;
    bus_read(ADDR_W'(0), rd);
    check("R8 busy engine", {31'h0, rd[31]}, 1);
    eng_busy = 1'b0;
    bus_read(ADDR_W'(0), rd);
    check("R8 idle", {31'h0, rd[31]}, 0);

    repeat (4) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule